// File: doc/BRIEF.md
# Lockable Control and Status Register Bank

This block is a small bank of control and status registers behind a simple synchronous access port. A shared address selects the register. A write strobe with write data updates the register on the clock edge that samples the strobe. A read strobe returns registered read data one clock later. The bank holds four register kinds:

- writable control fields;
- a read-only view of hardware status inputs;
- an event register that hardware sets and that clears when software reads it;
- a plain scratch register.

A command bit (`go`) is set by software and cleared by hardware with a completion pulse. A lock input stops software from changing the lockable control fields. The lock never stops the hardware completion pulse from clearing the command bit. Two reset domains coexist. The asynchronous active-low power-on reset returns every field to its reset value. A synchronous fault-clear pulse returns every field except the `keep` bit, which only power-on reset clears. Reset release is assumed synchronous to `clk_i`.

Register map (address: content):

- 0, control: bit 0 `go`, bit 1 `keep`, bits 7:4 `mode`, other bits read 0.
- 1, status.
- 2, events.
- 3, scratch.

Top module: `csr_lock_bank`

## Requirements
- R1: After power-on reset the bank holds its reset values. Control (address 0) reads 0x0050, which is `go`=0, `keep`=0 and `mode`=5. Scratch (address 3) reads 0xA5C3 and events (address 2) read 0.
- R2: Read data appears on `rdata_o` on the clock edge after the one that samples `rd_en_i`, and holds while `rd_en_i` is low. A write takes effect on the edge that samples `wr_en_i`, so a read issued on the next cycle returns the new value.
- R3: A `go_done_i` pulse clears `go` (address 0 bit 0) on that edge, whether or not `lock_i` is high. The pulse takes priority over a software write in the same cycle.
- R4: While `lock_i` is high, software writes leave `go` (bit 0) and `mode` (bits 7:4) of address 0 unchanged. `keep` (bit 1) stays writable.
- R5: `keep` (address 0 bit 1) is cleared only by power-on reset. A `fault_clr_i` pulse leaves it unchanged.
- R6: A `fault_clr_i` pulse returns `go` to 0, `mode` to 5, scratch to 0xA5C3 and the event bits to 0 on that edge. Any event set in the same cycle is kept.
- R7: Address 1 returns `hw_status_i` as sampled on the read edge. Writes to address 1 have no effect.
- R8: Address 2 holds the event bits. Each bit is set by a one-cycle high on the matching bit of `evt_set_i`. A read returns the accumulated bits and clears them, and writes have no effect.
- R9: An event set that arrives in the same cycle as a read of address 2 is not lost. The read returns the old bits, and the new event is held for the next read.
- R10: A read of an unmapped address (4 or higher) returns 0. A write to an unmapped address changes no register.
- R11: Address 3 is a full-width read-write scratch register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous assert |
| fault_clr_i | input | 1 | Synchronous fault reset pulse |
| addr_i | input | ADDR_W | Register address for read and write |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Registered read data |
| lock_i | input | 1 | Write lock for `go` and `mode` |
| go_done_i | input | 1 | Hardware completion pulse that clears `go` |
| hw_status_i | input | DATA_W | Hardware status shown at address 1 |
| evt_set_i | input | DATA_W | Hardware event set pulses for address 2 |
| go_o | output | 1 | Current `go` command bit |
| keep_o | output | 1 | Current `keep` bit |
| mode_o | output | MODE_W | Current `mode` field |

## Verification
The assertions check the following on every cycle:

- the completion pulse clears `go`, and the lock holds `go` and `mode`;
- `keep` survives a fault while the fault restores the other fields;
- event sets always land;
- status reads mirror the input;
- unmapped reads return zero;
- read data holds between reads.

Only the bench scenarios can show the following:

- the read-to-clear sequence across two reads;
- a set racing a clearing read;
- the exact order of lock, then completion pulse, then read;
- the absence of side effects from writes to read-only and unmapped addresses.

These scenarios are checked against a reference model driven by mixed random traffic.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  localparam int CSR_ADDR_CTRL    = 0;
  localparam int CSR_ADDR_STATUS  = 1;
  localparam int CSR_ADDR_EVT     = 2;
  localparam int CSR_ADDR_SCRATCH = 3;
  localparam int CSR_NUM_REGS     = 4;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_KEEP_BIT = 1;

  typedef struct packed {
    logic ctrl;
    logic status;
    logic evt;
    logic scratch;
  } csr_sel_t;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output csr_sel_t          sel_o
);

  always_comb begin
    sel_o         = '0;
    sel_o.ctrl    = (addr_i == ADDR_W'(CSR_ADDR_CTRL));
    sel_o.status  = (addr_i == ADDR_W'(CSR_ADDR_STATUS));
    sel_o.evt     = (addr_i == ADDR_W'(CSR_ADDR_EVT));
    sel_o.scratch = (addr_i == ADDR_W'(CSR_ADDR_SCRATCH));
  end

endmodule

// File: rtl/csr_rw_field.sv
module csr_rw_field #(
  parameter int           W            = 1,
  parameter logic [W-1:0] RST          = '0,
  parameter bit           LOCKABLE     = 1'b0,
  parameter bit           FAULT_DOMAIN = 1'b1,
  parameter bit           AUTO_CLR     = 1'b0
) (
  input  logic         clk_i,
  input  logic         por_n_i,
  input  logic         fault_clr_i,
  input  logic         lock_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         hw_clr_i,
  output logic [W-1:0] q_o
);

  localparam logic LOCK_EN = LOCKABLE;
  localparam logic FLT_EN  = FAULT_DOMAIN;
  localparam logic CLR_EN  = AUTO_CLR;

  logic         wr_ok;
  logic         clr_hit;
  logic         flt_hit;
  logic         q_en;
  logic [W-1:0] q_d;
  logic [W-1:0] q_q;

  // The lock gates only the software path; hardware clear and fault bypass it.
  assign wr_ok   = wr_i & ~(lock_i & LOCK_EN);
  assign clr_hit = hw_clr_i & CLR_EN;
  assign flt_hit = fault_clr_i & FLT_EN;

  always_comb begin
    q_en = flt_hit | clr_hit | wr_ok;
    q_d  = q_q;
    if (flt_hit) begin
      q_d = RST;
    end else if (clr_hit) begin
      q_d = '0;
    end else if (wr_ok) begin
      q_d = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      q_q <= RST;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/csr_rc_field.sv
module csr_rc_field #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         por_n_i,
  input  logic         fault_clr_i,
  input  logic         rd_clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_d;
  logic [W-1:0] q_q;
  logic         q_en;
  logic         wipe;

  assign wipe = rd_clr_i | fault_clr_i;
  assign q_en = wipe | (|set_i);

  // Per bit: a set in the same cycle as a wipe survives.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q_d[i] = (q_q[i] & ~wipe) | set_i[i];
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      q_q <= '0;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/csr_read_port.sv
module csr_read_port
  import csr_bank_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              por_n_i,
  input  logic              rd_en_i,
  input  csr_sel_t          sel_i,
  input  logic [DATA_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] evt_i,
  input  logic [DATA_W-1:0] scratch_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  // An unmapped address selects nothing, so the OR-mux yields zero.
  always_comb begin
    rdata_d = ({DATA_W{sel_i.ctrl}}    & ctrl_i)
            | ({DATA_W{sel_i.status}}  & status_i)
            | ({DATA_W{sel_i.evt}}     & evt_i)
            | ({DATA_W{sel_i.scratch}} & scratch_i);
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/csr_lock_bank.sv
module csr_lock_bank
  import csr_bank_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 16,
  parameter int                MODE_W      = 4,
  parameter int                MODE_LSB    = 4,
  parameter logic [MODE_W-1:0] MODE_RST    = 4'h5,
  parameter logic [DATA_W-1:0] SCRATCH_RST = 16'hA5C3
) (
  input  logic              clk_i,
  input  logic              por_n_i,
  input  logic              fault_clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              lock_i,
  input  logic              go_done_i,
  input  logic [DATA_W-1:0] hw_status_i,
  input  logic [DATA_W-1:0] evt_set_i,
  output logic              go_o,
  output logic              keep_o,
  output logic [MODE_W-1:0] mode_o
);

  localparam int MODE_MSB = MODE_LSB + MODE_W - 1;

  csr_sel_t          sel;
  logic              wr_ctrl;
  logic              wr_scratch;
  logic              rd_evt;
  logic              go_q;
  logic              keep_q;
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] scratch_q;
  logic [DATA_W-1:0] evt_q;
  logic [DATA_W-1:0] ctrl_rd;

  csr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wr_ctrl    = wr_en_i & sel.ctrl;
  assign wr_scratch = wr_en_i & sel.scratch;
  assign rd_evt     = rd_en_i & sel.evt;

  csr_rw_field #(
    .W(1), .RST(1'b0), .LOCKABLE(1'b1), .FAULT_DOMAIN(1'b1), .AUTO_CLR(1'b1)
  ) u_go (
    .clk_i       (clk_i),
    .por_n_i     (por_n_i),
    .fault_clr_i (fault_clr_i),
    .lock_i      (lock_i),
    .wr_i        (wr_ctrl),
    .wdata_i     (wdata_i[CTRL_GO_BIT]),
    .hw_clr_i    (go_done_i),
    .q_o         (go_q)
  );

  csr_rw_field #(
    .W(1), .RST(1'b0), .LOCKABLE(1'b0), .FAULT_DOMAIN(1'b0), .AUTO_CLR(1'b0)
  ) u_keep (
    .clk_i       (clk_i),
    .por_n_i     (por_n_i),
    .fault_clr_i (fault_clr_i),
    .lock_i      (lock_i),
    .wr_i        (wr_ctrl),
    .wdata_i     (wdata_i[CTRL_KEEP_BIT]),
    .hw_clr_i    (1'b0),
    .q_o         (keep_q)
  );

  csr_rw_field #(
    .W(MODE_W), .RST(MODE_RST), .LOCKABLE(1'b1), .FAULT_DOMAIN(1'b1), .AUTO_CLR(1'b0)
  ) u_mode (
    .clk_i       (clk_i),
    .por_n_i     (por_n_i),
    .fault_clr_i (fault_clr_i),
    .lock_i      (lock_i),
    .wr_i        (wr_ctrl),
    .wdata_i     (wdata_i[MODE_MSB:MODE_LSB]),
    .hw_clr_i    (1'b0),
    .q_o         (mode_q)
  );

  csr_rw_field #(
    .W(DATA_W), .RST(SCRATCH_RST), .LOCKABLE(1'b0), .FAULT_DOMAIN(1'b1), .AUTO_CLR(1'b0)
  ) u_scratch (
    .clk_i       (clk_i),
    .por_n_i     (por_n_i),
    .fault_clr_i (fault_clr_i),
    .lock_i      (lock_i),
    .wr_i        (wr_scratch),
    .wdata_i     (wdata_i),
    .hw_clr_i    (1'b0),
    .q_o         (scratch_q)
  );

  csr_rc_field #(.W(DATA_W)) u_evt (
    .clk_i       (clk_i),
    .por_n_i     (por_n_i),
    .fault_clr_i (fault_clr_i),
    .rd_clr_i    (rd_evt),
    .set_i       (evt_set_i),
    .q_o         (evt_q)
  );

  always_comb begin
    ctrl_rd                     = '0;
    ctrl_rd[CTRL_GO_BIT]        = go_q;
    ctrl_rd[CTRL_KEEP_BIT]      = keep_q;
    ctrl_rd[MODE_MSB:MODE_LSB]  = mode_q;
  end

  csr_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk_i     (clk_i),
    .por_n_i   (por_n_i),
    .rd_en_i   (rd_en_i),
    .sel_i     (sel),
    .ctrl_i    (ctrl_rd),
    .status_i  (hw_status_i),
    .evt_i     (evt_q),
    .scratch_i (scratch_q),
    .rdata_o   (rdata_o)
  );

  assign go_o   = go_q;
  assign keep_o = keep_q;
  assign mode_o = mode_q;

endmodule

// File: rtl/csr_lock_bank_checker.sv
module csr_lock_bank_checker
  import csr_bank_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 16,
  parameter int                MODE_W      = 4,
  parameter logic [MODE_W-1:0] MODE_RST    = 4'h5,
  parameter logic [DATA_W-1:0] SCRATCH_RST = 16'hA5C3
) (
  input logic              clk_i,
  input logic              por_n_i,
  input logic              fault_clr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              lock_i,
  input logic              go_done_i,
  input logic [DATA_W-1:0] hw_status_i,
  input logic [DATA_W-1:0] evt_set_i,
  input logic              go_o,
  input logic              keep_o,
  input logic [MODE_W-1:0] mode_o,
  input logic [DATA_W-1:0] scratch_q,
  input logic [DATA_W-1:0] evt_q
);

  assert_rdata_hold_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !rd_en_i |=> $stable(rdata_o));

  assert_go_clear_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
    go_done_i |=> !go_o);

  assert_lock_hold_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    lock_i && !go_done_i && !fault_clr_i |=> $stable(go_o) && $stable(mode_o));

  assert_keep_fault_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
    fault_clr_i && !(wr_en_i && addr_i == ADDR_W'(CSR_ADDR_CTRL)) |=> $stable(keep_o));

  assert_fault_restore_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    fault_clr_i |=> !go_o && (mode_o == MODE_RST) && (scratch_q == SCRATCH_RST));

  assert_status_read_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    rd_en_i && addr_i == ADDR_W'(CSR_ADDR_STATUS) |=> rdata_o == $past(hw_status_i));

  assert_evt_set_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (|evt_set_i) |=> ((evt_q & $past(evt_set_i)) == $past(evt_set_i)));

  assert_unmapped_R10: assert property (@(posedge clk_i) disable iff (!por_n_i)
    rd_en_i && addr_i >= ADDR_W'(CSR_NUM_REGS) |=> rdata_o == '0);

endmodule

bind csr_lock_bank csr_lock_bank_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W),
  .MODE_RST(MODE_RST), .SCRATCH_RST(SCRATCH_RST)
) u_chk (
  .clk_i       (clk_i),
  .por_n_i     (por_n_i),
  .fault_clr_i (fault_clr_i),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .rdata_o     (rdata_o),
  .lock_i      (lock_i),
  .go_done_i   (go_done_i),
  .hw_status_i (hw_status_i),
  .evt_set_i   (evt_set_i),
  .go_o        (go_o),
  .keep_o      (keep_o),
  .mode_o      (mode_o),
  .scratch_q   (scratch_q),
  .evt_q       (evt_q)
);

// File: tb/csr_lock_bank_bench.sv
module csr_lock_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SCR_RST = 16'hA5C3;
  localparam logic [3:0]  MOD_RST = 4'h5;

  logic        clk;
  logic        por_n;
  logic        fault_clr;
  logic [3:0]  addr;
  logic        wr_en;
  logic [15:0] wdata;
  logic        rd_en;
  logic [15:0] rdata;
  logic        lock;
  logic        go_done;
  logic [15:0] status;
  logic [15:0] evt_set;
  logic        go;
  logic        keep;
  logic [3:0]  mode;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic        m_go, m_keep;
  logic [3:0]  m_mode;
  logic [15:0] m_scr, m_evt;

  csr_lock_bank u_csr_lock_bank (
    .clk_i(clk), .por_n_i(por_n), .fault_clr_i(fault_clr), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata),
    .lock_i(lock), .go_done_i(go_done), .hw_status_i(status), .evt_set_i(evt_set),
    .go_o(go), .keep_o(keep), .mode_o(mode)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [15:0] exp_read(input logic [3:0] a, input logic [15:0] st);
    case (a)
      4'd0:    return {8'h00, m_mode, 2'b00, m_keep, m_go};
      4'd1:    return st;
      4'd2:    return m_evt;
      4'd3:    return m_scr;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_for(input logic [3:0] a);
    case (a)
      4'd0:    return "R2 R3 R4 R5 R6";
      4'd1:    return "R7";
      4'd2:    return "R8 R9";
      4'd3:    return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic model_reset();
    m_go = 1'b0; m_keep = 1'b0; m_mode = MOD_RST; m_scr = SCR_RST; m_evt = '0;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access cycle: called at a negedge, returns at the following negedge.
  task automatic cycle(input logic [3:0] a, input logic w, input logic [15:0] wd,
                       input logic r, input logic lk, input logic dn, input logic ft,
                       input logic [15:0] st, input logic [15:0] es, input string tag);
    logic [15:0] exp;
    logic [15:0] base;
    addr = a; wr_en = w; wdata = wd; rd_en = r; lock = lk; go_done = dn;
    fault_clr = ft; status = st; evt_set = es;
    exp = exp_read(a, st);
    // next-state of the model
    if (w && a == 4'd0) m_keep = wd[1];
    if (ft) begin
      m_go = 1'b0; m_mode = MOD_RST; m_scr = SCR_RST;
    end else begin
      if (dn) m_go = 1'b0;
      else if (w && a == 4'd0 && !lk) m_go = wd[0];
      if (w && a == 4'd0 && !lk) m_mode = wd[7:4];
      if (w && a == 4'd3) m_scr = wd;
    end
    base = (ft || (r && a == 4'd2)) ? 16'h0000 : m_evt;
    m_evt = base | es;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; go_done = 1'b0; fault_clr = 1'b0; evt_set = '0;
    if (r) check(tag, rdata, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic lk, input string tag);
    cycle(a, 1'b1, d, 1'b0, lk, 1'b0, 1'b0, status, 16'h0, tag);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cycle(a, 1'b0, 16'h0, 1'b1, lock, 1'b0, 1'b0, status, 16'h0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] hold;
    void'($urandom(32'h5EED_1234));
    por_n = 1'b0; fault_clr = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0; rd_en = 1'b0;
    lock = 1'b0; go_done = 1'b0; status = 16'h0; evt_set = '0;
    model_reset();
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1: reset state, literal values
    check("R1 go/keep", {14'h0, keep, go}, 16'h0000);
    rd(4'd0, "R1"); check("R1 ctrl literal", rdata, 16'h0050);
    rd(4'd3, "R1"); check("R1 scratch literal", rdata, 16'hA5C3);
    rd(4'd2, "R1");

    // R2: write then immediate read
    wr(4'd0, 16'h00A3, 1'b0, "R2");
    check("R2 go output after write", {15'h0, go}, 16'h0001);
    rd(4'd0, "R2"); check("R2 ctrl literal", rdata, 16'h00A3);
    // R2: rdata holds with no read strobe
    hold = rdata;
    cycle(4'd3, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, status, 16'h0, "R2");
    check("R2 rdata hold", rdata, hold);

    // R4: locked write leaves go and mode, keep still writable
    lock = 1'b1;
    wr(4'd0, 16'h0002, 1'b1, "R4");
    rd(4'd0, "R4"); check("R4 locked ctrl literal", rdata, 16'h00A3);
    wr(4'd0, 16'h0000, 1'b1, "R4");
    rd(4'd0, "R4"); check("R4 keep writable literal", rdata, 16'h00A1);
    wr(4'd0, 16'h0002, 1'b1, "R4");

    // R3: lock already high, completion pulse still clears go
    cycle(4'd0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, status, 16'h0, "R3");
    check("R3 go cleared under lock", {15'h0, go}, 16'h0000);
    rd(4'd0, "R3"); check("R3 ctrl literal", rdata, 16'h00A2);
    lock = 1'b0;

    // R5 R6: fault keeps keep, restores others
    wr(4'd3, 16'h1234, 1'b0, "R11");
    wr(4'd0, 16'h0073, 1'b0, "R6");
    cycle(4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, status, 16'h0, "R6");
    check("R5 keep after fault", {15'h0, keep}, 16'h0001);
    rd(4'd0, "R5 R6"); check("R5 R6 ctrl literal", rdata, 16'h0052);
    rd(4'd3, "R6"); check("R6 scratch literal", rdata, 16'hA5C3);

    // R7: status is read-only
    wr(4'd1, 16'hFFFF, 1'b0, "R7");
    status = 16'h3C3C;
    rd(4'd1, "R7"); check("R7 status literal", rdata, 16'h3C3C);

    // R8: read-to-clear
    cycle(4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, status, 16'h0011, "R8");
    wr(4'd2, 16'h0000, 1'b0, "R8");
    rd(4'd2, "R8"); check("R8 event literal", rdata, 16'h0011);
    rd(4'd2, "R8"); check("R8 cleared literal", rdata, 16'h0000);

    // R9: set racing a clearing read
    cycle(4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, status, 16'h0001, "R9");
    cycle(4'd2, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, status, 16'h0100, "R9");
    check("R9 old bits literal", rdata, 16'h0001);
    rd(4'd2, "R9"); check("R9 racing set kept literal", rdata, 16'h0100);

    // R10: unmapped
    wr(4'd5, 16'hFFFF, 1'b0, "R10");
    rd(4'd5, "R10"); check("R10 unmapped literal", rdata, 16'h0000);
    rd(4'd0, "R10");
    rd(4'd3, "R10");

    // R11: scratch read-write
    wr(4'd3, 16'hBEEF, 1'b0, "R11");
    rd(4'd3, "R11"); check("R11 scratch literal", rdata, 16'hBEEF);

    // Constrained random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  a;
      logic [15:0] es;
      a  = 4'($urandom_range(0, 6));
      es = ($urandom_range(0, 7) == 0) ? 16'($urandom) : 16'h0;
      cycle(a, ($urandom_range(0, 9) < 4), 16'($urandom), ($urandom_range(0, 9) < 6),
            $urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0,
            $urandom_range(0, 19) == 0, 16'($urandom), es, tag_for(a));
      if (i % 16 == 0) check("R3 R4 R5 R6 fields", {8'h0, mode, 2'b0, keep, go},
                             {8'h0, m_mode, 2'b0, m_keep, m_go});
    end

    // R1: power-on reset mid-run clears keep as well
    wr(4'd0, 16'h00F3, 1'b0, "R1");
    por_n = 1'b0;
    model_reset();
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 keep after por", {15'h0, keep}, 16'h0000);
    rd(4'd0, "R1"); check("R1 ctrl after por literal", rdata, 16'h0050);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule